// File: doc/BRIEF.md
# Serial Peripheral Slave Port with Write-Collision Flag

This block is the slave side of a four-wire synchronous serial link. An external master frames each byte with an active-low select line and toggles a serial clock. The block moves one byte in from the master-out line and one byte out on the master-in line during each byte. Two configuration inputs choose the clock polarity and the clock phase, so all four conventional modes are covered. All serial inputs are first brought into the system clock domain, and serial clock edges are found there, so the system clock has to run several times faster than the serial clock.

On the processor side there is a write port that loads the transmit shifter and a parallel read buffer that holds the last complete received byte. A transfer-complete flag is cleared by a status read followed by a data read. A write-collision flag reports a load attempted in the middle of a phase-0 frame and stays set until it is cleared with a strobe. A direction input decides whether the block drives the output pin at all.

Top module: `spi_slv`

## Requirements
- R1: After reset `tcFlag`=0, `wcolFlag`=0, `rxData`=0x00, and with `misoDir`=0 both `misoOe` and `misoOut` are 0.
- R2: Bits are received most significant bit first. After eight sampling edges inside one frame, `rxData` holds the byte the master sent. This holds in all four modes.
- R3: Bits are sent most significant bit first from the byte last loaded through `wrEn`/`wrData`. The idle level of `sckIn` equals `cpol`. With `cpha`=0 the slave samples on the first edge away from idle and changes its output on the return edge, and the first bit is valid as soon as `ssNIn` falls. With `cpha`=1 the output changes on the first edge and the slave samples on the return edge.
- R4: With `cpha`=1, `ssNIn` may stay low across back-to-back bytes. Each group of eight sampling edges forms one byte, and a write between the bytes loads the next byte to send.
- R5: `tcFlag` is set after the eighth sampling edge. A `rdStatus` pulse while `tcFlag`=1, followed later by a `rdData` pulse, clears it. A `rdData` pulse with no such status read leaves it set.
- R6: With `cpha`=0, a `wrEn` pulse while `ssNIn` is low sets `wcolFlag`, and the shifter keeps the byte it already held.
- R7: `wcolFlag` stays set until a `wcolClr` pulse. A write with `cpha`=1 and `ssNIn` low does not set it.
- R8: With `misoDir`=0, `misoOe` is 0 and `misoOut` is 0. With `misoDir`=1, `misoOe` is 1 and `misoOut` carries the current output bit.
- R9: If `ssNIn` rises before the eighth sampling edge, the partial byte is dropped. `tcFlag` stays 0, `rxData` is unchanged, and the next full byte is received correctly.
- R10: Serial clock edges while `ssNIn` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 samples on the first edge, 1 samples on the second edge |
| misoDir | input | 1 | Output pin direction, 1 = driven |
| sckIn | input | 1 | Serial clock from the master |
| ssNIn | input | 1 | Active-low slave select |
| mosiIn | input | 1 | Serial data from the master |
| misoOut | output | 1 | Serial data to the master |
| misoOe | output | 1 | Output enable for the master-in pin |
| wrEn | input | 1 | Processor write strobe for the transmit byte |
| wrData | input | 8 | Transmit byte |
| rdStatus | input | 1 | Status-read strobe that arms the flag clear |
| rdData | input | 1 | Data-read strobe that completes the flag clear |
| rxData | output | 8 | Last complete received byte |
| tcFlag | output | 1 | Transfer complete |
| wcolClr | input | 1 | Clears the write-collision flag |
| wcolFlag | output | 1 | Write collision |

## Verification
The main sweep runs 64 distinct receive and transmit byte pairs through each of the four polarity and phase modes. It compares the received byte and the bits seen by the master against values computed in the bench. This separates a wrong sampling edge, a missing first-bit shift suppression and a bit-order mistake, because each of these corrupts one mode in a different way. Further patterns cover back-to-back phase-1 bytes with select held low, a write issued inside a phase-0 frame, a frame cut short by select, clock toggles with select high, and the pin with its direction bit off. Each of these isolates one rule about framing or about the flags.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic byteDone;
    logic abort;
  } spiStrb_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL[b]}};
        else       chain <= {chain[STAGES-2:0], din[b]};
      end
      assign dout[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpol,
  input  logic     cpha,
  input  logic     sckRaw,
  input  logic     ssNRaw,
  input  logic     mosiRaw,
  input  logic     wrEn,
  input  logic     rdStatus,
  input  logic     rdData,
  input  logic     wcolClr,
  output spiStrb_t strb,
  output logic     mosiBit,
  output logic     tcFlag,
  output logic     wcolFlag
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [2:0] syncOut;
  logic sckS, ssS, ssPrev, normPrev, sckNorm, ssActive;
  logic leadEdge, trailEdge, launch, collide;
  logic [CNT_W-1:0] bitCnt;
  logic tcArmed;

  spi_slv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({mosiRaw, ssNRaw, sckRaw}),
    .dout(syncOut)
  );
  assign sckS    = syncOut[0];
  assign ssS     = syncOut[1];
  assign mosiBit = syncOut[2];

  assign ssActive = ~ssS;
  assign sckNorm  = sckS ^ cpol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      normPrev <= 1'b0;
      ssPrev   <= 1'b1;
    end else begin
      normPrev <= sckNorm;
      ssPrev   <= ssS;
    end
  end

  assign leadEdge  = ssActive & sckNorm & ~normPrev;
  assign trailEdge = ssActive & ~sckNorm & normPrev;
  assign launch    = cpha ? leadEdge : trailEdge;
  assign collide   = wrEn & ~cpha & ssActive;

  always_comb begin
    strb.sampleRx = cpha ? trailEdge : leadEdge;
    strb.shiftTx  = launch & ~(cpha & (bitCnt == '0));
    strb.loadTx   = wrEn & ~collide;
    strb.byteDone = strb.sampleRx & (bitCnt == LAST);
    strb.abort    = ssS & ~ssPrev & (bitCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bitCnt <= '0;
    else if (!ssActive)        bitCnt <= '0;
    else if (strb.sampleRx)    bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcFlag  <= 1'b0;
      tcArmed <= 1'b0;
    end else begin
      if (strb.byteDone)             tcFlag <= 1'b1;
      else if (rdData && tcArmed)    tcFlag <= 1'b0;
      if (rdStatus && tcFlag)        tcArmed <= 1'b1;
      else if (rdData)               tcArmed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         wcolFlag <= 1'b0;
    else if (collide)  wcolFlag <= 1'b1;
    else if (wcolClr)  wcolFlag <= 1'b0;
  end

  // R5
  tc_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tcFlag) |-> $past(strb.byteDone));
  // R5
  tc_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tcFlag) |-> $past(rdData));
  // R6
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wcolFlag) |-> $past(wrEn && !cpha && !ssS));
  // R7
  wcol_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wcolFlag) |-> $past(wcolClr));
  // R9
  frame_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ssS |=> (bitCnt == '0));
endmodule

// File: rtl/spi_slv_dp.sv
module spi_slv_dp
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrb_t          strb,
  input  logic              mosiBit,
  input  logic [DATA_W-1:0] wrData,
  input  logic              misoDir,
  output logic [DATA_W-1:0] rxData,
  output logic              misoOut,
  output logic              misoOe
);
  logic [DATA_W-1:0] rxShift, txShift, rxNext;

  assign rxNext = {rxShift[DATA_W-2:0], mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxShift <= '0;
    else if (strb.abort)    rxShift <= '0;
    else if (strb.sampleRx) rxShift <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxData <= '0;
    else if (strb.byteDone) rxData <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= '0;
    else if (strb.loadTx)  txShift <= wrData;
    else if (strb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  assign misoOe  = misoDir;
  assign misoOut = misoDir & txShift[DATA_W-1];

  // R2
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.byteDone) |-> $stable(rxData));
  // R6
  tx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadTx) |-> (txShift == $past(wrData)));
endmodule

// File: rtl/spi_slv.sv
module spi_slv
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              misoDir,
  input  logic              sckIn,
  input  logic              ssNIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStatus,
  input  logic              rdData,
  output logic [DATA_W-1:0] rxData,
  output logic              tcFlag,
  input  logic              wcolClr,
  output logic              wcolFlag
);
  spiStrb_t strb;
  logic mosiBit;

  spi_slv_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha),
    .sckRaw(sckIn), .ssNRaw(ssNIn), .mosiRaw(mosiIn),
    .wrEn(wrEn), .rdStatus(rdStatus), .rdData(rdData), .wcolClr(wcolClr),
    .strb(strb), .mosiBit(mosiBit), .tcFlag(tcFlag), .wcolFlag(wcolFlag)
  );

  spi_slv_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiBit(mosiBit),
    .wrData(wrData), .misoDir(misoDir),
    .rxData(rxData), .misoOut(misoOut), .misoOe(misoOe)
  );
endmodule

// File: tb/spi_slv_bench.sv
module spi_slv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN, cpol, cpha, misoDir, sck, ssN, mosi;
  logic wrEn, rdStatus, rdData, wcolClr;
  logic [7:0] wrData;
  logic misoOut, misoOe, tcFlag, wcolFlag;
  logic [7:0] rxData;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slv u_spi_slv (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .misoDir(misoDir),
    .sckIn(sck), .ssNIn(ssN), .mosiIn(mosi), .misoOut(misoOut), .misoOe(misoOe),
    .wrEn(wrEn), .wrData(wrData), .rdStatus(rdStatus), .rdData(rdData),
    .rxData(rxData), .tcFlag(tcFlag), .wcolClr(wcolClr), .wcolFlag(wcolFlag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    if (which == 0) rdStatus = 1'b1;
    else if (which == 1) rdData = 1'b1;
    else wcolClr = 1'b1;
    waitClk(1);
    rdStatus = 1'b0; rdData = 1'b0; wcolClr = 1'b0;
    waitClk(2);
  endtask

  task automatic cpuWrite(input logic [7:0] b);
    wrEn = 1'b1; wrData = b;
    waitClk(1);
    wrEn = 1'b0;
    waitClk(2);
  endtask

  task automatic setMode(input int m);
    cpol = m[1]; cpha = m[0]; sck = m[1];
    waitClk(HALF);
  endtask

  task automatic xfer(input logic [7:0] mo, input int nBits, input bit keep,
                      output logic [7:0] mi);
    mi = '0;
    if (ssN) begin ssN = 1'b0; waitClk(HALF); end
    for (int i = 0; i < nBits; i++) begin
      if (!cpha) begin
        mosi = mo[7-i]; waitClk(HALF);
        mi[7-i] = misoOut; sck = ~cpol; waitClk(HALF);
        sck = cpol;
      end else begin
        sck = ~cpol; mosi = mo[7-i]; waitClk(HALF);
        mi[7-i] = misoOut; sck = cpol; waitClk(HALF);
      end
    end
    waitClk(HALF);
    if (!keep) begin ssN = 1'b1; waitClk(HALF); end
  endtask

  task automatic clearTc();
    pulse(0); pulse(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] got, v, t;
    rstN = 1'b0; cpol = 1'b0; cpha = 1'b0; misoDir = 1'b0; sck = 1'b0; ssN = 1'b1;
    mosi = 1'b0; wrEn = 1'b0; wrData = '0; rdStatus = 1'b0; rdData = 1'b0; wcolClr = 1'b0;
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    // R1 reset state
    chk(tcFlag == 1'b0, "R1 tcFlag", tcFlag, 0);
    chk(wcolFlag == 1'b0, "R1 wcolFlag", wcolFlag, 0);
    chk(rxData == 8'h00, "R1 rxData", rxData, 0);
    chk(misoOe == 1'b0 && misoOut == 1'b0, "R1 miso pin", {misoOe, misoOut}, 0);

    // R8 direction gating
    cpuWrite(8'hFF);
    chk(misoOe == 1'b0 && misoOut == 1'b0, "R8 pin off", {misoOe, misoOut}, 0);
    misoDir = 1'b1; waitClk(1);
    chk(misoOe == 1'b1 && misoOut == 1'b1, "R8 pin on", {misoOe, misoOut}, 3);

    // R2 R3 sweep over modes and byte values
    for (int m = 0; m < 4; m++) begin
      setMode(m);
      for (int k = 0; k < 64; k++) begin
        v = 8'((k * 73 + m * 29 + 5) & 255);
        t = 8'((k * 151 + m * 7 + 200) & 255);
        cpuWrite(t);
        xfer(v, 8, 1'b0, got);
        chk(rxData == v, "R2 rx byte", rxData, v);
        chk(got == t, "R3 tx byte", got, t);
        chk(tcFlag == 1'b1, "R5 tc set", tcFlag, 1);
        clearTc();
        chk(tcFlag == 1'b0, "R5 tc clear", tcFlag, 0);
      end
    end

    // R4 back-to-back bytes with select held low, mode 3
    setMode(3);
    cpuWrite(8'hA5);
    xfer(8'h3C, 8, 1'b1, got);
    chk(rxData == 8'h3C && got == 8'hA5, "R4 first byte", {rxData, got}, 16'h3CA5);
    cpuWrite(8'h5A);
    // R7 write with cpha=1 and select low does not collide
    chk(wcolFlag == 1'b0, "R7 no collision cpha1", wcolFlag, 0);
    xfer(8'hC3, 8, 1'b0, got);
    chk(rxData == 8'hC3 && got == 8'h5A, "R4 second byte", {rxData, got}, 16'hC35A);

    // R5 data read alone does not clear
    pulse(1);
    chk(tcFlag == 1'b1, "R5 data read alone", tcFlag, 1);
    clearTc();
    chk(tcFlag == 1'b0, "R5 status then data", tcFlag, 0);

    // R6 collision in a phase-0 frame
    setMode(0);
    cpuWrite(8'h96);
    ssN = 1'b0; waitClk(HALF);
    cpuWrite(8'h0F);
    chk(wcolFlag == 1'b1, "R6 wcol set", wcolFlag, 1);
    xfer(8'h81, 8, 1'b0, got);
    chk(got == 8'h96, "R6 shifter kept", got, 8'h96);
    chk(wcolFlag == 1'b1, "R7 wcol held", wcolFlag, 1);
    pulse(2);
    chk(wcolFlag == 1'b0, "R7 wcol cleared", wcolFlag, 0);
    clearTc();

    // R9 select rises mid-byte
    setMode(1);
    cpuWrite(8'h11);
    xfer(8'hFF, 3, 1'b0, got);
    chk(tcFlag == 1'b0, "R9 no tc", tcFlag, 0);
    chk(rxData == 8'h81, "R9 rx unchanged", rxData, 8'h81);
    cpuWrite(8'h22);
    xfer(8'h4E, 8, 1'b0, got);
    chk(rxData == 8'h4E && got == 8'h22, "R9 next byte", {rxData, got}, 16'h4E22);
    clearTc();

    // R10 clock toggles with select high
    setMode(2);
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1; sck = ~cpol; waitClk(HALF); sck = cpol; waitClk(HALF);
    end
    chk(tcFlag == 1'b0, "R10 no tc", tcFlag, 0);
    cpuWrite(8'hE7);
    xfer(8'h29, 8, 1'b0, got);
    chk(rxData == 8'h29 && got == 8'hE7, "R10 byte after idle clocks", {rxData, got}, 16'h29E7);

    // R8 receive works with pin off, output stays low
    clearTc();
    misoDir = 1'b0;
    cpuWrite(8'hFF);
    xfer(8'h77, 8, 1'b0, got);
    chk(got == 8'h00 && misoOe == 1'b0, "R8 gated output", {misoOe, got}, 0);
    chk(rxData == 8'h77, "R8 rx with pin off", rxData, 8'h77);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule